// File: doc/BRIEF.md
# DRAM Strobe Sequencer with Open-Row Tracking

This block sits between a simple host request port and an asynchronous DRAM with a multiplexed address bus. The host gives one request at a time: a flat address, a write flag and write data. The sequencer turns each request into active-low row strobe, column strobe and write enable transitions. It returns read data in a register and pulses a one-clock ready.

The row opened by the last access is kept open. A later request to the same row goes straight to a column cycle with the row strobe still low. A request to a different row lowers nothing new until the old row has been closed and the precharge time has run out. A close input, meant for a refresh scheduler, closes the open row at the next point where no access is in flight. All analog delays are parameters counted in clock cycles. The wait from row strobe to column strobe is derived from the row and column access delays, so that read data is sampled only after both have been met.

Top module: `dram_seq`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `ready` is low and `rdata` is zero.
- R2: The host address is split into a row field (`addr[19:10]`) and a column field (`addr[9:0]`). The row field is on `dram_a` when `dram_ras_n` falls, and the column field is on `dram_a` when `dram_cas_n` falls.
- R3: Once a row has been open, `dram_ras_n` stays high for at least `T_PRE` clock cycles before it falls again.
- R4: `dram_cas_n` falls only while `dram_ras_n` is low, and `dram_ras_n` rises only while `dram_cas_n` is high.
- R5: `dram_we_n` is low only while `dram_cas_n` is low and the request is a write. `dram_d` then carries the request's write data.
- R6: Read data is sampled from `dram_q` no earlier than `T_RAC` cycles after the row strobe fell and no earlier than `T_CAC` cycles after the column strobe fell. The sampled word appears on `rdata`.
- R7: `ready` is high for exactly one cycle per accepted request. A write leaves `rdata` unchanged.
- R8: A request to the row that is open is served with no new row strobe fall; only the column strobe pulses.
- R9: A request to a different row raises `dram_ras_n`, waits out precharge, then opens the new row and completes the access.
- R10: A `close_row` pulse while a row is open raises `dram_ras_n` once the block is between accesses. A pulse during an access is held until that access has finished. A pulse while no row is open has no effect.
- R11: If `close_row` and a request to the open row arrive in the same cycle, the close wins. The request is then served as a row miss, with one new row strobe fall.
- R12: `dram_a` is stable for as long as `dram_cas_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request; held until `ready` |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Flat address, row field above column field |
| wdata | input | 8 | Write data |
| close_row | input | 1 | Close the open row at the next idle point |
| rdata | output | 8 | Last word read |
| ready | output | 1 | One-cycle completion pulse |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_d | output | 8 | Data to the memory |
| dram_q | input | 8 | Data from the memory |

## Verification
The close input and a page-hit request can reach the open-row state in the same clock cycle. The bench provokes this by raising `close_row` and `req` on the same clock edge while the requested row is already open. It judges the outcome at the memory pins: exactly one new row strobe fall must be counted during the access, which shows a close followed by a reopen. The read must also return the stored word. The bench also checks that a close pulse arriving mid-access does not disturb that access and still closes the row afterwards.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ROWSET = 3'd1,
    S_ROWACT = 3'd2,
    S_COLSET = 3'd3,
    S_COL    = 3'd4,
    S_DONE   = 3'd5,
    S_OPEN   = 3'd6,
    S_PRE    = 3'd7
  } dseq_state_e;

  // Cycles spent with RAS low before the column setup cycle. Row strobe low
  // time at data capture equals this + 1 (column setup) + cac.
  function automatic int ras_to_cas(input int rac, input int cac);
    int d;
    d = rac - cac - 1;
    return (d < 1) ? 1 : d;
  endfunction

  function automatic int wider(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dseq_timer.sv
module dseq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= len - TW'(1);
    else if (cnt != '0)     cnt <= cnt - TW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dseq_rowtrack.sv
module dseq_rowtrack #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_evt,
  input  logic             close_evt,
  input  logic [ROW_W-1:0] row_in,
  input  logic [ROW_W-1:0] probe_row,
  output logic             hit
);
  logic             valid;
  logic [ROW_W-1:0] open_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      open_row <= '0;
    end else if (close_evt) begin
      valid    <= 1'b0;
    end else if (open_evt) begin
      valid    <= 1'b1;
      open_row <= row_in;
    end
  end

  assign hit = valid && (probe_row == open_row);
endmodule

// File: rtl/dseq_amux.sv
module dseq_amux #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int AW    = 10
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             sel_col,
  output logic [AW-1:0]    a
);
  always_comb begin
    a = '0;
    if (sel_col) a[COL_W-1:0] = col;
    else         a[ROW_W-1:0] = row;
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dseq_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int DATA_W = 8,
  parameter int T_PRE  = 3,
  parameter int T_RAC  = 5,
  parameter int T_CAC  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   wr,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   close_row,
  output logic [DATA_W-1:0]      rdata,
  output logic                   ready,
  output logic [wider(ROW_W, COL_W)-1:0] dram_a,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [DATA_W-1:0]      dram_d,
  input  logic [DATA_W-1:0]      dram_q
);
  localparam int AW  = wider(ROW_W, COL_W);
  localparam int HW  = ROW_W + COL_W;
  localparam int RCD = ras_to_cas(T_RAC, T_CAC);
  localparam int TW  = 8;

  dseq_state_e state, nxt;

  logic              wr_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;
  logic              pend_req;
  logic              close_pend;

  logic              t_load, t_exp;
  logic [TW-1:0]     t_len;
  logic              row_hit;
  logic              sel_col;

  // named internal events, used by the bound checker
  logic ev_accept, ev_capture, ev_hit_go, st_open, ev_open, ev_close;

  assign st_open    = (state == S_OPEN);
  assign ev_accept  = req && ((state == S_IDLE) || st_open);
  assign ev_capture = (state == S_COL) && t_exp && !wr_q;
  assign ev_hit_go  = st_open && (nxt == S_COLSET);
  assign ev_open    = (nxt == S_ROWACT) && (state != S_ROWACT);
  assign ev_close   = (nxt == S_PRE) && (state != S_PRE);

  dseq_rowtrack #(.ROW_W(ROW_W)) u_rows (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_evt  (ev_open),
    .close_evt (ev_close),
    .row_in    (row_q),
    .probe_row (addr[HW-1:COL_W]),
    .hit       (row_hit)
  );

  dseq_timer #(.TW(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .len     (t_len),
    .expired (t_exp)
  );

  // next-state logic
  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:   if (req) nxt = S_ROWSET;
      S_ROWSET: nxt = S_ROWACT;
      S_ROWACT: if (t_exp) nxt = S_COLSET;
      S_COLSET: nxt = S_COL;
      S_COL:    if (t_exp) nxt = S_DONE;
      S_DONE:   nxt = S_OPEN;
      S_OPEN: begin
        if (close_row || close_pend) nxt = S_PRE;
        else if (req)                nxt = row_hit ? S_COLSET : S_PRE;
      end
      S_PRE:    if (t_exp) nxt = pend_req ? S_ROWSET : S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_comb begin
    t_load = (nxt != state) &&
             ((nxt == S_ROWACT) || (nxt == S_COL) || (nxt == S_PRE));
    unique case (nxt)
      S_ROWACT: t_len = TW'(RCD);
      S_COL:    t_len = TW'(T_CAC);
      default:  t_len = TW'(T_PRE);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  // request latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else if (ev_accept) begin
      wr_q    <= wr;
      row_q   <= addr[HW-1:COL_W];
      col_q   <= addr[COL_W-1:0];
      wdata_q <= wdata;
    end
  end

  // a request that must wait for a row to close and precharge
  always_ff @(posedge clk) begin
    if (!rst_n)                                        pend_req <= 1'b0;
    else if (state == S_ROWSET)                        pend_req <= 1'b0;
    else if (st_open && req && (nxt == S_PRE))         pend_req <= 1'b1;
  end

  // close request held until the next idle point
  always_ff @(posedge clk) begin
    if (!rst_n)                                        close_pend <= 1'b0;
    else if (state == S_PRE)                           close_pend <= 1'b0;
    else if (close_row && (state != S_IDLE))           close_pend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          rdata <= '0;
    else if (ev_capture) rdata <= dram_q;
  end

  // pin decode
  assign sel_col = (state == S_COLSET) || (state == S_COL) ||
                   (state == S_DONE)   || st_open;

  dseq_amux #(.ROW_W(ROW_W), .COL_W(COL_W), .AW(AW)) u_amux (
    .row     (row_q),
    .col     (col_q),
    .sel_col (sel_col),
    .a       (dram_a)
  );

  assign dram_ras_n = !((state == S_ROWACT) || (state == S_COLSET) ||
                        (state == S_COL)    || (state == S_DONE) || st_open);
  assign dram_cas_n = (state != S_COL);
  assign dram_we_n  = !((state == S_COL) && wr_q);
  assign dram_d     = wdata_q;
  assign ready      = (state == S_DONE);

endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
  parameter int T_PRE = 3,
  parameter int T_RAC = 5,
  parameter int T_CAC = 2,
  parameter int AW    = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          ready,
  input logic [AW-1:0] a,
  input logic          ev_capture,
  input logic          ev_hit_go,
  input logic          st_open,
  input logic          close_pend
);
  logic [7:0] pre_cnt, ras_cnt, cas_cnt;
  logic       was_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      ras_cnt  <= '0;
      cas_cnt  <= '0;
      was_open <= 1'b0;
    end else begin
      pre_cnt  <= !ras_n ? 8'd0 : ((pre_cnt == 8'hFF) ? pre_cnt : pre_cnt + 8'd1);
      ras_cnt  <= ras_n  ? 8'd0 : ((ras_cnt == 8'hFF) ? ras_cnt : ras_cnt + 8'd1);
      cas_cnt  <= cas_n  ? 8'd0 : ((cas_cnt == 8'hFF) ? cas_cnt : cas_cnt + 8'd1);
      if (!ras_n) was_open <= 1'b1;
    end
  end

  assert_ras_precharge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && was_open) |-> (int'(pre_cnt) >= T_PRE));

  assert_cas_under_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> !ras_n);

  assert_ras_rise_cas_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);

  assert_we_inside_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cas_n);

  assert_read_after_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |-> ((int'(ras_cnt) + 1 >= T_RAC) && (int'(cas_cnt) + 1 >= T_CAC)));

  assert_ready_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  assert_page_hit_keeps_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit_go |=> !ras_n);

  assert_close_at_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_open && close_pend) |=> ras_n);

  assert_col_addr_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(a));

endmodule

bind dram_seq dseq_chk #(
  .T_PRE (T_PRE),
  .T_RAC (T_RAC),
  .T_CAC (T_CAC),
  .AW    (AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ras_n      (dram_ras_n),
  .cas_n      (dram_cas_n),
  .we_n       (dram_we_n),
  .ready      (ready),
  .a          (dram_a),
  .ev_capture (ev_capture),
  .ev_hit_go  (ev_hit_go),
  .st_open    (st_open),
  .close_pend (close_pend)
);

// File: tb/sim_dram_seq.sv
`timescale 1ns/1ps
module sim_dram_seq;
  localparam int T_PRE = 3;
  localparam int T_RAC = 5;
  localparam int T_CAC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, close_row = 1'b0;
  logic [19:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ready;
  logic [9:0]  dram_a;
  logic        dram_ras_n, dram_cas_n, dram_we_n;
  logic [7:0]  dram_d, dram_q;

  always #10 clk = ~clk;   // 50 MHz

  dram_seq #(.T_PRE(T_PRE), .T_RAC(T_RAC), .T_CAC(T_CAC)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .close_row(close_row), .rdata(rdata), .ready(ready), .dram_a(dram_a),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_d(dram_d), .dram_q(dram_q)
  );

  int checks = 0;
  int errors = 0;

  // ---------------- memory model and pin monitor ----------------
  logic [7:0] mem [256];
  logic [9:0] row_l = '0, col_l = '0, a_prev = '0;
  logic       ras_prev = 1'b1, cas_prev = 1'b1, rdy_prev = 1'b0, opened = 1'b0;
  int rcnt = 0, ccnt = 0, hi_cnt = 0;
  int ras_falls = 0, pre_viol = 0, cas_viol = 0, we_viol = 0;
  int stab_viol = 0, rdy_cnt = 0, rdy_long = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  assign dram_q = (!dram_cas_n && dram_we_n && (rcnt + 1 >= T_RAC) && (ccnt + 1 >= T_CAC))
                  ? mem[{row_l[3:0], dram_a[3:0]}] : 8'hEE;

  always @(posedge clk) begin
    ras_prev <= dram_ras_n;
    cas_prev <= dram_cas_n;
    rdy_prev <= ready;
    a_prev   <= dram_a;
    rcnt     <= dram_ras_n ? 0 : rcnt + 1;
    ccnt     <= dram_cas_n ? 0 : ccnt + 1;
    hi_cnt   <= dram_ras_n ? hi_cnt + 1 : 0;
    if (rst_n) begin
      if (ras_prev && !dram_ras_n) begin
        ras_falls <= ras_falls + 1;
        row_l     <= dram_a;
        if (opened && hi_cnt < T_PRE) pre_viol <= pre_viol + 1;
        opened    <= 1'b1;
      end
      if (cas_prev && !dram_cas_n) begin
        col_l <= dram_a;
        if (dram_ras_n) cas_viol <= cas_viol + 1;
      end
      if (!cas_prev && !dram_cas_n && dram_a != a_prev) stab_viol <= stab_viol + 1;
      if (!dram_we_n && dram_cas_n) we_viol <= we_viol + 1;
      if (!dram_cas_n && !dram_we_n) mem[{row_l[3:0], dram_a[3:0]}] <= dram_d;
      if (ready) rdy_cnt <= rdy_cnt + 1;
      if (ready && rdy_prev) rdy_long <= rdy_long + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int acc_cnt = 0;

  // cmode: 0 none, 1 close_row with the request, 2 close_row two cycles into it
  task automatic access(input logic w, input logic [19:0] a, input logic [7:0] d,
                        input int cmode, output int nfall);
    int f0;
    int n;
    f0 = ras_falls;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    close_row = (cmode == 1);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      close_row = (cmode == 2 && n == 2);
      if (ready || n > 200) break;
    end
    req = 1'b0;
    close_row = 1'b0;
    acc_cnt++;
    check(n <= 200, "R7 ready timeout", n, 200);
    @(negedge clk);
    nfall = ras_falls - f0;
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic        w;
    logic [19:0] a;
    logic [7:0]  d;
    logic [7:0]  exp_rd;
    logic [1:0]  falls;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b1, 20'h01403, 8'hA1, 8'h00, 2'd1},   // open row 5 from closed
    '{1'b1, 20'h01407, 8'hB2, 8'h00, 2'd0},   // page hit write
    '{1'b0, 20'h01403, 8'h00, 8'hA1, 2'd0},   // page hit read
    '{1'b1, 20'h02403, 8'hC3, 8'hA1, 2'd1},   // miss to row 9
    '{1'b0, 20'h01407, 8'h00, 8'hB2, 2'd1},   // miss back to row 5
    '{1'b0, 20'h02403, 8'h00, 8'hC3, 2'd1},   // miss to row 9
    '{1'b0, 20'h02403, 8'h00, 8'hC3, 2'd0},   // hit
    '{1'b1, 20'hFFFFF, 8'hDD, 8'hC3, 2'd1},   // top row/col, write keeps rdata
    '{1'b0, 20'hFFFFF, 8'h00, 8'hDD, 2'd0},
    '{1'b0, 20'h01403, 8'h00, 8'hA1, 2'd1}
  };

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R7 actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nf;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle", {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    check(!ready && rdata == 8'h00, "R1 ready/rdata", {ready, rdata}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      access(VEC[i].w, VEC[i].a, VEC[i].d, 0, nf);
      check(rdata == VEC[i].exp_rd, $sformatf("R6 R7 vec%0d rdata", i), rdata, VEC[i].exp_rd);
      check(nf == int'(VEC[i].falls), $sformatf("R8 R9 vec%0d ras falls", i), nf, VEC[i].falls);
      check(row_l == VEC[i].a[19:10] && col_l == VEC[i].a[9:0],
            $sformatf("R2 vec%0d row/col split", i), {row_l, col_l}, VEC[i].a);
    end

    // R10: close while open and idle; next access to same row reopens it
    @(negedge clk); close_row = 1'b1;
    @(negedge clk); close_row = 1'b0;
    repeat (T_PRE + 2) @(negedge clk);
    check(dram_ras_n, "R10 idle close raises RAS", dram_ras_n, 1);
    access(1'b0, 20'h01407, 8'h00, 0, nf);
    check(rdata == 8'hB2 && nf == 1, "R10 reopen after close", {nf[7:0], rdata}, {8'd1, 8'hB2});

    // R10: close with no open row has no effect
    @(negedge clk); close_row = 1'b1;
    @(negedge clk); close_row = 1'b0;
    repeat (T_PRE + 2) @(negedge clk);
    @(negedge clk); close_row = 1'b1;
    @(negedge clk); close_row = 1'b0;
    repeat (3) @(negedge clk);
    check(dram_ras_n && dram_cas_n, "R10 close when closed", {dram_ras_n, dram_cas_n}, 2'b11);
    access(1'b0, 20'h02403, 8'h00, 0, nf);
    check(rdata == 8'hC3 && nf == 1, "R10 access after idle close", {nf[7:0], rdata}, {8'd1, 8'hC3});

    // R11: close and page-hit request in the same cycle
    access(1'b0, 20'h02403, 8'h00, 1, nf);
    check(nf == 1, "R11 close wins over hit", nf, 1);
    check(rdata == 8'hC3, "R11 data after forced miss", rdata, 8'hC3);

    // R10: close during an access is deferred, access unharmed
    access(1'b1, 20'h02405, 8'h5A, 0, nf);
    access(1'b0, 20'h02403, 8'h00, 2, nf);
    check(nf == 0 && rdata == 8'hC3, "R10 close mid-access keeps hit", {nf[7:0], rdata}, {8'd0, 8'hC3});
    repeat (2) @(negedge clk);
    check(dram_ras_n, "R10 deferred close raises RAS", dram_ras_n, 1);
    access(1'b0, 20'h02405, 8'h00, 0, nf);
    check(rdata == 8'h5A && nf == 1, "R5 written word read back", {nf[7:0], rdata}, {8'd1, 8'h5A});

    repeat (4) @(negedge clk);
    check(pre_viol == 0, "R3 precharge kept", pre_viol, 0);
    check(cas_viol == 0, "R4 CAS only under RAS", cas_viol, 0);
    check(we_viol == 0, "R5 WE only with CAS", we_viol, 0);
    check(rdy_long == 0 && rdy_cnt == acc_cnt, "R7 one ready per request", rdy_cnt, acc_cnt);
    check(stab_viol == 0, "R12 address stable under CAS", stab_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule